// File: doc/BRIEF.md
# Secondary PLL Configuration Sequencer

This block owns the two 32-bit control words that set up a secondary PLL. It also runs a hardware sequence that brings that PLL up from a single start strobe. The caller presents a target multiplier and reference divider and pulses `start`. The block records the targets and raises `busy`. It then waits until the primary clock subsystem reports `pri_ready`. After that it steps the control fields in a fixed order, one field change per clock, and the two words drive the PLL macro's control pins directly.

The bandwidth-adjust value is derived in hardware as half the multiplier, rounded down. Its low byte goes into word 0 and its upper nibble into word 1. After programming, the block keeps the PLL in reset for `RST_HOLD` cycles, releases it, and then waits `LOCK_WAIT` cycles to model lock. Only then does it leave bypass and pulse `done`. While the block is idle, software can read and write both words through a small register port. Writes land only in the defined fields.

A separate toggle flop divides a PLL-output tick by two, giving an enable for a downstream coprocessor clock.

Top module: `pll_cfg_seq`

## Requirements
- R1: After a synchronous active-low reset, both control words read 0, `busy` and `done` are 0 and `div2_q` is 0.
- R2: Word 0 (address 0) layout: bits 31:24 bandwidth low byte, bit 23 bypass (1 = bypassed), bits 22:19 reserved, bits 18:6 multiplier, bits 5:0 divider. A software write keeps only the defined bits, so writing all ones reads back 0xFF87FFFF.
- R3: Word 1 (address 1) layout: bit 14 PLL reset (1 = held in reset), bit 6 saturation enable, bits 3:0 bandwidth upper nibble. All other bits read 0, so writing all ones reads back 0x0000404F.
- R4: The programmed 12-bit bandwidth value equals the multiplier shifted right by one (15 gives 7). Its bits 7:0 go to word 0 bits 31:24 and its bits 11:8 to word 1 bits 3:0.
- R5: Let edge 0 be the edge that accepts the start, and let k count the edges after the primary-ready input is first sampled high, with k = 1 on that edge. Saturation enable sets at k = 2, bypass sets at k = 3, PLL reset asserts at k = 4, and the multiplier, divider and bandwidth fields load at k = 5. The loaded values are the targets present at edge 0, even if the inputs change later.
- R6: An accepted start waits, with `busy` high and no field changed, for as long as `pri_ready` is low.
- R7: PLL reset releases at k = 5 + RST_HOLD + 1, bypass clears at k = 7 + RST_HOLD + LOCK_WAIT, and `done` is high for exactly that one cycle.
- R8: `busy` is high from edge 0 until the cycle in which `done` rises. While busy, software writes and further start strobes have no effect.
- R9: `sw_rdata` shows word 0 when `sw_addr` is 0 and word 1 when it is 1, in the same cycle.
- R10: `div2_q` inverts on each clock where `pll_tick` is high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tgt_mult | input | 13 | Target multiplier, captured on start |
| tgt_div | input | 6 | Target reference divider, captured on start |
| start | input | 1 | Start request, accepted when idle |
| pri_ready | input | 1 | Primary PLL and controller initialized |
| sw_we | input | 1 | Software write strobe |
| sw_addr | input | 1 | Word select (0 or 1) |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Read data of the selected word |
| pll_tick | input | 1 | One pulse per PLL output clock |
| ctl0 | output | 32 | Live control word 0 |
| ctl1 | output | 32 | Live control word 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| div2_q | output | 1 | PLL tick divided by two |

## Verification
The assertions take for granted that `pri_ready`, `start` and the software strobe are synchronous to `clk`. They also assume the sequencer is the only agent changing the words while `busy` is high. The ordering checks therefore rely on software writes being discarded during a run rather than reordered. The stimulus changes inputs only just after a clock edge. It overlaps software writes and repeat start strobes with a running sequence, to show they are dropped instead of racing the steps. It uses small hold and lock counts so that a sweep over many multiplier and divider values stays short.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared field positions, masks, state and step encodings for the
// secondary PLL configuration sequencer. Assumes the fixed 32-bit word layout.
package pll_seq_pkg;

    localparam int MULT_W = 13;
    localparam int DIV_W  = 6;
    localparam int BW_W   = MULT_W - 1;

    localparam int W0_BWLO_LSB = 24;
    localparam int W0_BYP_BIT  = 23;
    localparam int W0_MULT_LSB = 6;
    localparam int W0_DIV_LSB  = 0;
    localparam int W1_RST_BIT  = 14;
    localparam int W1_SAT_BIT  = 6;
    localparam int W1_BWHI_LSB = 0;

    localparam logic [31:0] W0_MASK = 32'hFF87_FFFF;
    localparam logic [31:0] W1_MASK = 32'h0000_404F;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WAIT, ST_SAT, ST_BYP, ST_RST, ST_PROG,
        ST_HOLD, ST_REL, ST_LOCK, ST_UNBYP, ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_SAT, OP_BYP_ON, OP_RST_ON, OP_PROG, OP_RST_OFF, OP_BYP_OFF
    } seq_op_e;

    // Bandwidth adjust is half the multiplier, rounded down.
    function automatic logic [BW_W-1:0] bw_of(input logic [MULT_W-1:0] m);
        return m[MULT_W-1:1];
    endfunction

endpackage

// File: rtl/pll_seq_fsm.sv
`timescale 1ns/1ps
// Module: sequencer state machine. Accepts a start when idle, waits for the
// primary clock ready flag, then issues one field-update step per state.
// A shared counter times the reset hold and lock wait.
// Assumes RST_HOLD >= 1 and LOCK_WAIT >= 1, and inputs synchronous to clk.
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int RST_HOLD  = 8,
    parameter int LOCK_WAIT = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    pri_ready,
    output seq_op_e op,
    output logic    accept,
    output logic    busy,
    output logic    done
);

    localparam int MAX_WAIT = (RST_HOLD > LOCK_WAIT) ? RST_HOLD : LOCK_WAIT;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_HOLD - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_WAIT - 1);

    seq_state_e         state, nxt;
    logic [CNT_W-1:0]   cnt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_WAIT;
            ST_WAIT:  if (pri_ready) nxt = ST_SAT;
            ST_SAT:   nxt = ST_BYP;
            ST_BYP:   nxt = ST_RST;
            ST_RST:   nxt = ST_PROG;
            ST_PROG:  nxt = ST_HOLD;
            ST_HOLD:  if (cnt == HOLD_LAST) nxt = ST_REL;
            ST_REL:   nxt = ST_LOCK;
            ST_LOCK:  if (cnt == LOCK_LAST) nxt = ST_UNBYP;
            ST_UNBYP: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Wait counter: cleared on every state change, counts in the timed states.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt <= '0;
        else if (nxt != state)                       cnt <= '0;
        else if (state == ST_HOLD || state == ST_LOCK) cnt <= cnt + 1'b1;
    end

    // Step decode: one register update per step state.
    always_comb begin
        unique case (state)
            ST_SAT:   op = OP_SAT;
            ST_BYP:   op = OP_BYP_ON;
            ST_RST:   op = OP_RST_ON;
            ST_PROG:  op = OP_PROG;
            ST_REL:   op = OP_RST_OFF;
            ST_UNBYP: op = OP_BYP_OFF;
            default:  op = OP_NONE;
        endcase
    end

    // Status outputs.
    assign accept = (state == ST_IDLE) && start;
    assign busy   = (state != ST_IDLE) && (state != ST_DONE);
    assign done   = (state == ST_DONE);

    p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !pri_ready) |=> (state == ST_WAIT && busy));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_hold_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD || state == ST_LOCK) |-> (cnt < CNT_W'(MAX_WAIT)));
    p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

// File: rtl/pll_ctl_regs.sv
`timescale 1ns/1ps
// Module: the two PLL control words. Sequencer steps take priority; software
// writes are masked to the defined fields and dropped while busy.
// Assumes op is OP_NONE whenever the sequencer is idle.
module pll_ctl_regs
    import pll_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  seq_op_e           op,
    input  logic              busy,
    input  logic [MULT_W-1:0] mult,
    input  logic [DIV_W-1:0]  div,
    input  logic              sw_we,
    input  logic              sw_addr,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       w0,
    output logic [31:0]       w1
);

    logic [BW_W-1:0] bw;

    // Derived bandwidth value for the programming step.
    assign bw = bw_of(mult);

    // Word update: sequencer step, else an idle software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w0 <= '0;
            w1 <= '0;
        end else begin
            unique case (op)
                OP_SAT:     w1[W1_SAT_BIT] <= 1'b1;
                OP_BYP_ON:  w0[W0_BYP_BIT] <= 1'b1;
                OP_RST_ON:  w1[W1_RST_BIT] <= 1'b1;
                OP_PROG: begin
                    w0[W0_BWLO_LSB +: 8]     <= bw[7:0];
                    w0[W0_MULT_LSB +: MULT_W] <= mult;
                    w0[W0_DIV_LSB +: DIV_W]   <= div;
                    w1[W1_BWHI_LSB +: 4]     <= bw[BW_W-1:8];
                end
                OP_RST_OFF: w1[W1_RST_BIT] <= 1'b0;
                OP_BYP_OFF: w0[W0_BYP_BIT] <= 1'b0;
                default: begin
                    if (sw_we && !busy) begin
                        if (sw_addr) w1 <= sw_wdata & W1_MASK;
                        else         w0 <= sw_wdata & W0_MASK;
                    end
                end
            endcase
        end
    end

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((w0 & ~W0_MASK) == 32'h0) && ((w1 & ~W1_MASK) == 32'h0));
    p_rst_after_byp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RST_ON) |-> (w0[W0_BYP_BIT] && w1[W1_SAT_BIT]));
    p_prog_in_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PROG) |-> (w1[W1_RST_BIT] && w0[W0_BYP_BIT]));
    p_unbyp_after_rel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BYP_OFF) |-> !w1[W1_RST_BIT]);
    p_busy_write_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sw_we && op == OP_NONE) |=> ($stable(w0) && $stable(w1)));

endmodule

// File: rtl/pll_div2.sv
`timescale 1ns/1ps
// Module: toggle flop dividing the PLL output tick by two, used as the
// downstream coprocessor clock enable. Assumes tick is synchronous to clk.
module pll_div2 (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic q
);

    // Toggle on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (tick) q <= ~q;
    end

    p_div2_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(q));

endmodule

// File: rtl/pll_cfg_seq.sv
`timescale 1ns/1ps
// Module: top of the secondary PLL configuration sequencer. Captures the
// targets on an accepted start, runs the step sequence, exposes both
// control words and a read port, and divides the PLL tick by two.
// Assumes all inputs are synchronous to clk.
module pll_cfg_seq
    import pll_seq_pkg::*;
#(
    parameter int RST_HOLD  = 8,
    parameter int LOCK_WAIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [12:0] tgt_mult,
    input  logic [5:0]  tgt_div,
    input  logic        start,
    input  logic        pri_ready,
    input  logic        sw_we,
    input  logic        sw_addr,
    input  logic [31:0] sw_wdata,
    output logic [31:0] sw_rdata,
    input  logic        pll_tick,
    output logic [31:0] ctl0,
    output logic [31:0] ctl1,
    output logic        busy,
    output logic        done,
    output logic        div2_q
);

    seq_op_e            op;
    logic               accept;
    logic [MULT_W-1:0]  mult_q;
    logic [DIV_W-1:0]   div_q;

    // Target capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_q <= '0;
            div_q  <= '0;
        end else if (accept) begin
            mult_q <= tgt_mult;
            div_q  <= tgt_div;
        end
    end

    pll_seq_fsm #(
        .RST_HOLD  (RST_HOLD),
        .LOCK_WAIT (LOCK_WAIT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pri_ready (pri_ready),
        .op        (op),
        .accept    (accept),
        .busy      (busy),
        .done      (done)
    );

    pll_ctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .busy     (busy),
        .mult     (mult_q),
        .div      (div_q),
        .sw_we    (sw_we),
        .sw_addr  (sw_addr),
        .sw_wdata (sw_wdata),
        .w0       (ctl0),
        .w1       (ctl1)
    );

    pll_div2 u_div2 (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (pll_tick),
        .q     (div2_q)
    );

    // Read mux.
    assign sw_rdata = sw_addr ? ctl1 : ctl0;

    p_no_start_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(mult_q) && $stable(div_q)));

endmodule

// File: tb/pll_cfg_seq_test.sv
`timescale 1ns/1ps
module pll_cfg_seq_test;

    localparam int H = 3;
    localparam int L = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] tgt_mult = '0;
    logic [5:0]  tgt_div = '0;
    logic        start = 1'b0;
    logic        pri_ready = 1'b0;
    logic        sw_we = 1'b0;
    logic        sw_addr = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        pll_tick = 1'b0;
    logic [31:0] ctl0, ctl1;
    logic        busy, done, div2_q;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [31:0] m0 = '0, m1 = '0;

    pll_cfg_seq #(.RST_HOLD(H), .LOCK_WAIT(L)) uut (
        .clk(clk), .rst_n(rst_n), .tgt_mult(tgt_mult), .tgt_div(tgt_div),
        .start(start), .pri_ready(pri_ready), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .pll_tick(pll_tick),
        .ctl0(ctl0), .ctl1(ctl1), .busy(busy), .done(done), .div2_q(div2_q)
    );

    always #4 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input logic a, input logic [31:0] d);
        sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        step();
        sw_we = 1'b0;
    endtask

    // One full sequence; w = cycles pri_ready stays low; noisy adds busy-time writes and starts.
    task automatic run_seq(input logic [12:0] mult, input logic [5:0] dv, input int w, input bit noisy);
        int last;
        logic [11:0] bw;
        bw = 12'(mult / 2);
        last = 9 + H + L + w;
        tgt_mult = mult; tgt_div = dv;
        pri_ready = (w == 0);
        start = 1'b1;
        for (int n = 0; n <= last; n++) begin
            int k;
            step();
            k = n - w;
            if (k == 2) m1[6] = 1'b1;
            if (k == 3) m0[23] = 1'b1;
            if (k == 4) m1[14] = 1'b1;
            if (k == 5) begin
                m0[31:24] = bw[7:0];
                m0[18:6]  = mult;
                m0[5:0]   = dv;
                m1[3:0]   = bw[11:8];
            end
            if (k == 6 + H) m1[14] = 1'b0;
            if (k == 7 + H + L) m0[23] = 1'b0;
            chk("R5/R4 ctl0", ctl0, m0);
            chk("R5/R4 ctl1", ctl1, m1);
            chk("R7 done", {31'b0, done}, {31'b0, (k == 7 + H + L)});
            chk("R8/R6 busy", {31'b0, busy}, {31'b0, (n <= 6 + H + L + w)});
            if (n == 0) begin
                start = 1'b0; tgt_mult = ~mult; tgt_div = ~dv;
            end
            if (w > 0 && n == w) pri_ready = 1'b1;
            if (noisy) begin
                start    = (n == 1);
                sw_we    = (n <= 4);
                sw_addr  = n[0];
                sw_wdata = 32'hFFFF_FFFF;
            end
        end
        sw_we = 1'b0; start = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic q;
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 ctl0", ctl0, 32'h0);
        chk("R1 ctl1", ctl1, 32'h0);
        chk("R1 busy", {31'b0, busy}, 32'h0);
        chk("R1 done", {31'b0, done}, 32'h0);
        chk("R1 div2", {31'b0, div2_q}, 32'h0);

        // R2/R3 masks, R9 read select
        sw_write(1'b0, 32'hFFFF_FFFF);
        sw_addr = 1'b0; #1;
        chk("R2 rdata", sw_rdata, 32'hFF87_FFFF);
        chk("R2 ctl0", ctl0, 32'hFF87_FFFF);
        sw_write(1'b1, 32'hFFFF_FFFF);
        sw_addr = 1'b1; #1;
        chk("R3 rdata", sw_rdata, 32'h0000_404F);
        sw_addr = 1'b0; #1;
        chk("R9 rdata sel0", sw_rdata, 32'hFF87_FFFF);
        sw_write(1'b0, 32'h1234_5678);
        sw_addr = 1'b1; #1;
        chk("R9 rdata sel1", sw_rdata, 32'h0000_404F);
        sw_addr = 1'b0; #1;
        chk("R2 partial", sw_rdata, 32'h1204_5678 & 32'hFF87_FFFF);
        sw_write(1'b0, 32'h0);
        sw_write(1'b1, 32'h0);
        m0 = '0; m1 = '0;

        // R5/R7 basic run, R4 odd multiplier
        run_seq(13'd15, 6'd3, 0, 1'b0);
        // R6 pending until ready, R8 busy-time writes and starts ignored
        run_seq(13'd200, 6'd17, 5, 1'b1);
        run_seq(13'd8191, 6'd63, 2, 1'b1);
        // R4 sweep of multiplier and divider values
        for (int i = 0; i < 150; i++)
            run_seq(13'((i * 1117 + i / 2) % 8192), 6'(i % 64), i % 3, 1'b0);
        run_seq(13'd0, 6'd0, 0, 1'b0);
        run_seq(13'd1, 6'd1, 0, 1'b0);

        // R10 divide-by-two
        q = div2_q;
        for (int i = 0; i < 40; i++) begin
            pll_tick = (i % 3 != 0);
            step();
            q = q ^ pll_tick;
            chk("R10 div2", {31'b0, div2_q}, {31'b0, q});
        end
        pll_tick = 1'b0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule